// File: doc/BRIEF.md
# Multithreaded Fetch Status Controller

This block keeps the fetch-side state of every hardware thread in a multithreaded front end. In each cycle it samples, per thread, the block, unblock and squash indications from the four stages downstream of fetch (decode, rename, execute, commit), a global context-switch request, miss issue and miss completion strobes from the instruction cache side, and trap or quiesce entry requests from the instruction delivery path. From these it computes the next state, PC and next PC of each thread, and reports whether any thread changed status in that cycle.

Every thread runs its own state machine with eight named states: RUN (fetching), IDLE (held; no rule enters it), SQUASH (redirected, draining), BLOCK (held by a downstream stall), MISS_WAIT (an instruction-cache miss is outstanding), MISS_DONE (the miss returned), TRAP and QUIESCE. The transitions are: RUN to MISS_WAIT on a miss issue; MISS_WAIT to MISS_DONE or BLOCK on a matching completion; MISS_DONE, BLOCK or SQUASH back to RUN when no rule fires; any state to SQUASH on a commit squash, a ROB-still-squashing indication or a decode squash; any state except MISS_WAIT to BLOCK on a stall; RUN to TRAP or QUIESCE on request. A stage-active flag tells the surrounding core whether fetch has useful work. A counter records the miss completions that arrive too late to be used.

Top module: `fetch_status_ctrl`

## Requirements
- R1: After reset every thread is in RUN, with PC equal to the reset vector (0) and next PC equal to 4. No status change is reported and the discarded-completion count is 0. States are reported 3 bits per thread at bits [3t+2:3t] with RUN=0, IDLE=1, SQUASH=2, BLOCK=3, MISS_WAIT=4, MISS_DONE=5, TRAP=6, QUIESCE=7.
- R2: Each of the four downstream sources has a sticky stall bit per thread. A block input sets the bit and an unblock input clears it. While any bit is set, or while the context-switch input is high, the thread goes to BLOCK in the next cycle. An unblock never comes with a block and never comes for a bit that is already clear.
- R3: Within a thread the rules have a fixed precedence: commit squash, then ROB still squashing, then decode squash, then stall, then the return to RUN from BLOCK or SQUASH.
- R4: A decode squash redirects a thread only when the thread is not in SQUASH. Otherwise the PC is kept and the lower-precedence rules apply.
- R5: A redirect loads PC with the target and next PC with target plus 4 (modulo 2^32), enters SQUASH, and discards any outstanding miss request of that thread.
- R6: A stall leaves a thread in MISS_WAIT unchanged.
- R7: A miss issue aimed at a thread that would otherwise stay in RUN moves it to MISS_WAIT and records the request tag.
- R8: A miss completion is discarded, and the 8-bit discard counter goes up by one, when the target thread is not in MISS_WAIT or when the tag differs from the recorded tag.
- R9: An accepted completion moves the thread to BLOCK if the thread is stalled and to MISS_DONE if it is not. MISS_DONE returns to RUN one cycle later.
- R10: TRAP and QUIESCE are entered from RUN on request. The thread stays there until a squash or a stall moves it.
- R11: The stage is active exactly when some active thread is in RUN, SQUASH or MISS_DONE.
- R12: The registered status-change flag is high in the cycle after any rule fired for an active thread.
- R13: A thread whose active bit is low keeps its state, PC and stall bits regardless of inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| thread_active | input | NT | Per-thread active mask |
| blk_dec | input | NT | Decode block, per thread |
| unblk_dec | input | NT | Decode unblock, per thread |
| blk_ren | input | NT | Rename block, per thread |
| unblk_ren | input | NT | Rename unblock, per thread |
| blk_exe | input | NT | Execute block, per thread |
| unblk_exe | input | NT | Execute unblock, per thread |
| blk_cmt | input | NT | Commit block, per thread |
| unblk_cmt | input | NT | Commit unblock, per thread |
| ctx_switch | input | 1 | Context-switch request, stalls all threads |
| cmt_squash | input | NT | Commit squash, per thread |
| cmt_rob_busy | input | NT | ROB still squashing, per thread |
| cmt_target | input | NT*PC_W | Commit redirect target per thread |
| dec_squash | input | NT | Decode squash, per thread |
| dec_target | input | NT*PC_W | Decode redirect target per thread |
| miss_vld | input | 1 | Miss issue strobe |
| miss_tid | input | TID_W | Thread of issued miss |
| miss_tag | input | TAG_W | Tag of issued miss |
| fill_vld | input | 1 | Miss completion strobe |
| fill_tid | input | TID_W | Thread of completion |
| fill_tag | input | TAG_W | Tag of completion |
| trap_req | input | NT | Trap entry request per thread |
| quiesce_req | input | NT | Quiesce entry request per thread |
| thr_state | output | 3*NT | Per-thread state code |
| thr_pc | output | NT*PC_W | Per-thread PC |
| thr_npc | output | NT*PC_W | Per-thread next PC |
| status_changed | output | 1 | Some thread changed status last cycle |
| stage_active | output | 1 | Fetch has useful work |
| stale_fill_cnt | output | CNT_W | Discarded-completion count |

## Verification
A miss completion and a downstream stall can land on the same thread in the same cycle. The bench parks a thread in MISS_WAIT, holds a decode stall on it, and then delivers a completion with the matching tag. The thread must go to BLOCK and not MISS_DONE, and it must return to RUN only after the unblock. A second collision is a commit squash against an outstanding miss: the late completion that follows must be counted as discarded while the thread leaves SQUASH normally.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
    typedef enum logic [2:0] {
        TS_RUN       = 3'd0,
        TS_IDLE      = 3'd1,
        TS_SQUASH    = 3'd2,
        TS_BLOCK     = 3'd3,
        TS_MISS_WAIT = 3'd4,
        TS_MISS_DONE = 3'd5,
        TS_TRAP      = 3'd6,
        TS_QUIESCE   = 3'd7
    } thr_state_e;

    localparam int NUM_STALL_SRC = 4;
endpackage

// File: rtl/fsc_stall_bank.sv
module fsc_stall_bank #(
    parameter int NSRC = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [NSRC-1:0] blk,
    input  logic [NSRC-1:0] unblk,
    output logic [NSRC-1:0] stall_nxt
);
    logic [NSRC-1:0] stall_q;

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        assign stall_nxt[s] = en ? ((stall_q[s] | blk[s]) & ~unblk[s]) : stall_q[s];
        always_ff @(posedge clk) begin
            if (!rst_n) stall_q[s] <= 1'b0;
            else        stall_q[s] <= stall_nxt[s];
        end
    end

    // R2
    unblk_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && |unblk) |-> (((unblk & ~stall_q) == '0) && ((unblk & blk) == '0)));
endmodule

// File: rtl/fsc_thread_fsm.sv
module fsc_thread_fsm
    import fsc_pkg::*;
#(
    parameter int              PC_W       = 32,
    parameter int              TAG_W      = 4,
    parameter int              INST_BYTES = 4,
    parameter logic [PC_W-1:0] RESET_PC   = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             active,
    input  logic             stalled,
    input  logic             cmt_sq,
    input  logic             rob_sq,
    input  logic [PC_W-1:0]  cmt_tgt,
    input  logic             dec_sq,
    input  logic [PC_W-1:0]  dec_tgt,
    input  logic             fill_hit,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             miss_issue,
    input  logic [TAG_W-1:0] miss_tag,
    input  logic             trap_set,
    input  logic             quiesce_set,
    output thr_state_e       state_q,
    output logic [PC_W-1:0]  pc_q,
    output logic [PC_W-1:0]  npc_q,
    output logic             changed,
    output logic             fill_drop
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INST_BYTES);

    thr_state_e       state_d, st_mid;
    logic [PC_W-1:0]  pc_d, npc_d, redir_tgt;
    logic             ovld_q, ovld_d, accept, redirect;
    logic [TAG_W-1:0] otag_q, otag_d;

    // Completion is resolved first, then the per-cycle signal rules.
    always_comb begin
        accept    = active && fill_hit && (state_q == TS_MISS_WAIT) && ovld_q && (fill_tag == otag_q);
        fill_drop = fill_hit && !accept;
        st_mid    = state_q;
        ovld_d    = ovld_q;
        otag_d    = otag_q;
        changed   = 1'b0;
        if (accept) begin
            st_mid  = stalled ? TS_BLOCK : TS_MISS_DONE;
            ovld_d  = 1'b0;
            changed = 1'b1;
        end

        redirect  = active && (cmt_sq || (!rob_sq && dec_sq && st_mid != TS_SQUASH));
        redir_tgt = cmt_sq ? cmt_tgt : dec_tgt;

        state_d = st_mid;
        pc_d    = pc_q;
        npc_d   = npc_q;

        if (redirect) begin
            state_d = TS_SQUASH;
            pc_d    = redir_tgt;
            npc_d   = redir_tgt + STEP;
            ovld_d  = 1'b0;
            changed = 1'b1;
        end else if (active && rob_sq) begin
            state_d = TS_SQUASH;
            changed = 1'b1;
        end else if (active && stalled && st_mid != TS_MISS_WAIT) begin
            state_d = TS_BLOCK;
            changed = 1'b1;
        end else if (active) begin
            unique case (st_mid)
                TS_BLOCK, TS_SQUASH: begin
                    state_d = TS_RUN;
                    changed = 1'b1;
                end
                TS_MISS_DONE: begin
                    if (state_q == TS_MISS_DONE) begin
                        state_d = TS_RUN;
                        changed = 1'b1;
                    end
                end
                TS_RUN: begin
                    if (trap_set) begin
                        state_d = TS_TRAP;
                        changed = 1'b1;
                    end else if (quiesce_set) begin
                        state_d = TS_QUIESCE;
                        changed = 1'b1;
                    end else if (miss_issue) begin
                        state_d = TS_MISS_WAIT;
                        ovld_d  = 1'b1;
                        otag_d  = miss_tag;
                        changed = 1'b1;
                    end
                end
                TS_IDLE, TS_MISS_WAIT, TS_TRAP, TS_QUIESCE: begin
                    state_d = st_mid;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TS_RUN;
            pc_q    <= RESET_PC;
            npc_q   <= RESET_PC + STEP;
            ovld_q  <= 1'b0;
            otag_q  <= '0;
        end else begin
            state_q <= state_d;
            pc_q    <= pc_d;
            npc_q   <= npc_d;
            ovld_q  <= ovld_d;
            otag_q  <= otag_d;
        end
    end

    // R5
    squash_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active && cmt_sq) |=> (state_q == TS_SQUASH) && (pc_q == $past(cmt_tgt)));
    // R6
    miss_no_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_MISS_WAIT) |=> (state_q != TS_RUN));
    // R10
    trap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == TS_TRAP && active && !cmt_sq && !rob_sq && !dec_sq && !stalled)
        |=> (state_q == TS_TRAP));
    // R13
    inactive_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> ($stable(state_q) && $stable(pc_q)));
endmodule

// File: rtl/fsc_status_merge.sv
module fsc_status_merge
    import fsc_pkg::*;
#(
    parameter int NT    = 4,
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NT-1:0]    active,
    input  logic [NT-1:0]    chg,
    input  logic [NT-1:0]    drop,
    input  thr_state_e       states [NT],
    output logic             status_changed,
    output logic             stage_active,
    output logic [CNT_W-1:0] stale_cnt
);
    logic [NT-1:0] busy;

    for (genvar t = 0; t < NT; t++) begin : g_busy
        assign busy[t] = active[t] && (states[t] == TS_RUN || states[t] == TS_SQUASH ||
                                       states[t] == TS_MISS_DONE);
    end

    assign stage_active = |busy;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_changed <= 1'b0;
            stale_cnt      <= '0;
        end else begin
            status_changed <= |(chg & active);
            stale_cnt      <= stale_cnt + CNT_W'(|drop);
        end
    end

    // R8
    cnt_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(|drop) |=> $stable(stale_cnt));
    // R11
    idle_stage_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (active == '0) |-> !stage_active);
endmodule

// File: rtl/fetch_status_ctrl.sv
module fetch_status_ctrl
    import fsc_pkg::*;
#(
    parameter int NT         = 4,
    parameter int PC_W       = 32,
    parameter int TAG_W      = 4,
    parameter int CNT_W      = 8,
    parameter int INST_BYTES = 4,
    localparam int TID_W     = (NT > 1) ? $clog2(NT) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NT-1:0]      thread_active,
    input  logic [NT-1:0]      blk_dec,
    input  logic [NT-1:0]      unblk_dec,
    input  logic [NT-1:0]      blk_ren,
    input  logic [NT-1:0]      unblk_ren,
    input  logic [NT-1:0]      blk_exe,
    input  logic [NT-1:0]      unblk_exe,
    input  logic [NT-1:0]      blk_cmt,
    input  logic [NT-1:0]      unblk_cmt,
    input  logic               ctx_switch,
    input  logic [NT-1:0]      cmt_squash,
    input  logic [NT-1:0]      cmt_rob_busy,
    input  logic [NT*PC_W-1:0] cmt_target,
    input  logic [NT-1:0]      dec_squash,
    input  logic [NT*PC_W-1:0] dec_target,
    input  logic               miss_vld,
    input  logic [TID_W-1:0]   miss_tid,
    input  logic [TAG_W-1:0]   miss_tag,
    input  logic               fill_vld,
    input  logic [TID_W-1:0]   fill_tid,
    input  logic [TAG_W-1:0]   fill_tag,
    input  logic [NT-1:0]      trap_req,
    input  logic [NT-1:0]      quiesce_req,
    output logic [3*NT-1:0]    thr_state,
    output logic [NT*PC_W-1:0] thr_pc,
    output logic [NT*PC_W-1:0] thr_npc,
    output logic               status_changed,
    output logic               stage_active,
    output logic [CNT_W-1:0]   stale_fill_cnt
);
    thr_state_e    st [NT];
    logic [NT-1:0] chg, drop;

    for (genvar t = 0; t < NT; t++) begin : g_thr
        logic [NUM_STALL_SRC-1:0] stall_nxt;

        fsc_stall_bank #(.NSRC(NUM_STALL_SRC)) u_stall (
            .clk       (clk),
            .rst_n     (rst_n),
            .en        (thread_active[t]),
            .blk       ({blk_cmt[t], blk_exe[t], blk_ren[t], blk_dec[t]}),
            .unblk     ({unblk_cmt[t], unblk_exe[t], unblk_ren[t], unblk_dec[t]}),
            .stall_nxt (stall_nxt)
        );

        fsc_thread_fsm #(
            .PC_W(PC_W), .TAG_W(TAG_W), .INST_BYTES(INST_BYTES)
        ) u_fsm (
            .clk         (clk),
            .rst_n       (rst_n),
            .active      (thread_active[t]),
            .stalled     (ctx_switch || (|stall_nxt)),
            .cmt_sq      (cmt_squash[t]),
            .rob_sq      (cmt_rob_busy[t]),
            .cmt_tgt     (cmt_target[t*PC_W +: PC_W]),
            .dec_sq      (dec_squash[t]),
            .dec_tgt     (dec_target[t*PC_W +: PC_W]),
            .fill_hit    (fill_vld && (fill_tid == TID_W'(t))),
            .fill_tag    (fill_tag),
            .miss_issue  (miss_vld && (miss_tid == TID_W'(t))),
            .miss_tag    (miss_tag),
            .trap_set    (trap_req[t]),
            .quiesce_set (quiesce_req[t]),
            .state_q     (st[t]),
            .pc_q        (thr_pc[t*PC_W +: PC_W]),
            .npc_q       (thr_npc[t*PC_W +: PC_W]),
            .changed     (chg[t]),
            .fill_drop   (drop[t])
        );

        assign thr_state[3*t +: 3] = st[t];
    end

    fsc_status_merge #(.NT(NT), .CNT_W(CNT_W)) u_merge (
        .clk            (clk),
        .rst_n          (rst_n),
        .active         (thread_active),
        .chg            (chg),
        .drop           (drop),
        .states         (st),
        .status_changed (status_changed),
        .stage_active   (stage_active),
        .stale_cnt      (stale_fill_cnt)
    );
endmodule

// File: tb/sim_fetch_status_ctrl.sv
module sim_fetch_status_ctrl;
    localparam int PERIOD = 10;
    localparam int NT = 4;
    localparam int PW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [NT-1:0] act, bd, ud, br, ur, be, ue, bc, uc, csq, rob, dsq, trp, qsc;
    logic ctx, mv, fv;
    logic [1:0] mt, ft;
    logic [3:0] mg, fg;
    logic [NT*PW-1:0] ctg, dtg;
    logic [3*NT-1:0] st;
    logic [NT*PW-1:0] pc, npc;
    logic chg, sact;
    logic [7:0] cnt;

    int n_run = 0;
    int n_fail = 0;

    always #(PERIOD/2) clk = ~clk;

    fetch_status_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .thread_active(act),
        .blk_dec(bd), .unblk_dec(ud), .blk_ren(br), .unblk_ren(ur),
        .blk_exe(be), .unblk_exe(ue), .blk_cmt(bc), .unblk_cmt(uc),
        .ctx_switch(ctx), .cmt_squash(csq), .cmt_rob_busy(rob), .cmt_target(ctg),
        .dec_squash(dsq), .dec_target(dtg),
        .miss_vld(mv), .miss_tid(mt), .miss_tag(mg),
        .fill_vld(fv), .fill_tid(ft), .fill_tag(fg),
        .trap_req(trp), .quiesce_req(qsc),
        .thr_state(st), .thr_pc(pc), .thr_npc(npc),
        .status_changed(chg), .stage_active(sact), .stale_fill_cnt(cnt)
    );

    typedef struct packed {
        logic [3:0]  blk;   // bit0 dec, bit1 ren, bit2 exe, bit3 cmt
        logic [3:0]  unblk;
        logic        ctx;
        logic        csq;
        logic        rob;
        logic        dsq;
        logic [31:0] tgt;   // commit target; decode target is tgt + 0x100
        logic [2:0]  est;
        logic [31:0] epc;
        logic        echg;
    } vec_t;

    localparam int NV = 16;
    localparam logic [79:0] TBL [NV] = '{
        {4'b0001, 4'b0000, 4'b0000, 32'h0,        3'd3, 32'h0,        1'b1}, // R2 block
        {4'b0000, 4'b0000, 4'b0000, 32'h0,        3'd3, 32'h0,        1'b1}, // R2 sticky
        {4'b0000, 4'b0001, 4'b0000, 32'h0,        3'd0, 32'h0,        1'b1}, // R2 unblock
        {4'b0000, 4'b0000, 4'b0000, 32'h0,        3'd0, 32'h0,        1'b0}, // R12 quiet
        {4'b0010, 4'b0000, 4'b0101, 32'h100,      3'd2, 32'h100,      1'b1}, // R3 commit wins
        {4'b0000, 4'b0000, 4'b0001, 32'h200,      3'd3, 32'h100,      1'b1}, // R4 no redirect
        {4'b0000, 4'b0010, 4'b0001, 32'h200,      3'd2, 32'h300,      1'b1}, // R4 redirect
        {4'b0000, 4'b0000, 4'b0011, 32'h300,      3'd2, 32'h300,      1'b1}, // R3 rob over decode
        {4'b0000, 4'b0000, 4'b1000, 32'h0,        3'd3, 32'h300,      1'b1}, // R2 context switch
        {4'b0000, 4'b0000, 4'b0000, 32'h0,        3'd0, 32'h300,      1'b1}, // R3 resume
        {4'b0000, 4'b0000, 4'b0100, 32'hFFFFFFFC, 3'd2, 32'hFFFFFFFC, 1'b1}, // R5 wrap
        {4'b0000, 4'b0000, 4'b0000, 32'h0,        3'd0, 32'hFFFFFFFC, 1'b1}, // R3 squash done
        {4'b1100, 4'b0000, 4'b0000, 32'h0,        3'd3, 32'hFFFFFFFC, 1'b1}, // R2 two sources
        {4'b0000, 4'b0100, 4'b0000, 32'h0,        3'd3, 32'hFFFFFFFC, 1'b1}, // R2 one left
        {4'b0000, 4'b1000, 4'b0000, 32'h0,        3'd0, 32'hFFFFFFFC, 1'b1}, // R2 all clear
        {4'b0000, 4'b0000, 4'b0000, 32'h0,        3'd0, 32'hFFFFFFFC, 1'b0}  // R12 quiet
    };

    task automatic clr();
        bd = '0; ud = '0; br = '0; ur = '0; be = '0; ue = '0; bc = '0; uc = '0;
        ctx = 1'b0; csq = '0; rob = '0; dsq = '0; ctg = '0; dtg = '0;
        mv = 1'b0; mt = '0; mg = '0; fv = 1'b0; ft = '0; fg = '0;
        trp = '0; qsc = '0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    function automatic logic [2:0] stt(input int t);
        return st[3*t +: 3];
    endfunction

    function automatic logic [31:0] pct(input int t);
        return pc[t*PW +: PW];
    endfunction

    function automatic logic [31:0] npct(input int t);
        return npc[t*PW +: PW];
    endfunction

    initial begin
        #(PERIOD * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        act = '1;
        clr();
        tick(); tick();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        for (int t = 0; t < NT; t++) begin
            chk("R1 state", 32'(stt(t)), 32'd0);
            chk("R1 pc", pct(t), 32'h0);
            chk("R1 npc", npct(t), 32'h4);
        end
        chk("R1 changed", 32'(chg), 32'd0);
        chk("R1 count", 32'(cnt), 32'd0);
        chk("R11 active at reset", 32'(sact), 32'd1);

        // Table walk on thread 0 (R2 R3 R4 R5 R12)
        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = vec_t'(TBL[i]);
            clr();
            bd[0] = v.blk[0]; br[0] = v.blk[1]; be[0] = v.blk[2]; bc[0] = v.blk[3];
            ud[0] = v.unblk[0]; ur[0] = v.unblk[1]; ue[0] = v.unblk[2]; uc[0] = v.unblk[3];
            ctx = v.ctx; csq[0] = v.csq; rob[0] = v.rob; dsq[0] = v.dsq;
            ctg[0 +: PW] = v.tgt; dtg[0 +: PW] = v.tgt + 32'h100;
            tick();
            chk("R3 table state", 32'(stt(0)), 32'(v.est));
            chk("R5 table pc", pct(0), v.epc);
            chk("R5 table npc", npct(0), v.epc + 32'd4);
            chk("R12 table changed", 32'(chg), 32'(v.echg));
        end
        clr();

        // R7 miss issue on thread 2
        mv = 1'b1; mt = 2'd2; mg = 4'd5;
        tick(); clr();
        chk("R7 miss wait", 32'(stt(2)), 32'd4);
        // R6 stall ignored in miss wait
        bd[2] = 1'b1;
        tick(); clr();
        chk("R6 stall ignored", 32'(stt(2)), 32'd4);
        // R8 wrong tag
        fv = 1'b1; ft = 2'd2; fg = 4'd3;
        tick(); clr();
        chk("R8 wrong tag state", 32'(stt(2)), 32'd4);
        chk("R8 wrong tag count", 32'(cnt), 32'd1);
        // R9 matching completion while stalled
        fv = 1'b1; ft = 2'd2; fg = 4'd5;
        tick(); clr();
        chk("R9 fill under stall", 32'(stt(2)), 32'd3);
        chk("R9 no count", 32'(cnt), 32'd1);
        ud[2] = 1'b1;
        tick(); clr();
        chk("R2 unblock after fill", 32'(stt(2)), 32'd0);
        // R9 completion without stall
        mv = 1'b1; mt = 2'd2; mg = 4'd6;
        tick(); clr();
        chk("R7 second miss", 32'(stt(2)), 32'd4);
        fv = 1'b1; ft = 2'd2; fg = 4'd6;
        tick(); clr();
        chk("R9 miss done", 32'(stt(2)), 32'd5);
        tick();
        chk("R9 back to run", 32'(stt(2)), 32'd0);
        chk("R12 change on resume", 32'(chg), 32'd1);
        // R8 completion to a running thread
        fv = 1'b1; ft = 2'd2; fg = 4'd6;
        tick(); clr();
        chk("R8 fill to running", 32'(cnt), 32'd2);

        // R5 squash drops outstanding miss on thread 3
        mv = 1'b1; mt = 2'd3; mg = 4'd1;
        tick(); clr();
        chk("R7 miss thread3", 32'(stt(3)), 32'd4);
        csq[3] = 1'b1; ctg[3*PW +: PW] = 32'h80;
        tick(); clr();
        chk("R5 squash state", 32'(stt(3)), 32'd2);
        chk("R5 squash pc", pct(3), 32'h80);
        chk("R5 squash npc", npct(3), 32'h84);
        fv = 1'b1; ft = 2'd3; fg = 4'd1;
        tick(); clr();
        chk("R5 dropped fill state", 32'(stt(3)), 32'd0);
        chk("R5 dropped fill count", 32'(cnt), 32'd3);

        // R10 trap on thread 1
        trp[1] = 1'b1;
        tick(); clr();
        chk("R10 trap entry", 32'(stt(1)), 32'd6);
        tick();
        chk("R10 trap held", 32'(stt(1)), 32'd6);
        chk("R12 no change", 32'(chg), 32'd0);
        dsq[1] = 1'b1; dtg[1*PW +: PW] = 32'h40;
        tick(); clr();
        chk("R10 trap exit", 32'(stt(1)), 32'd2);
        chk("R10 trap exit pc", pct(1), 32'h40);
        tick();
        chk("R10 run again", 32'(stt(1)), 32'd0);
        qsc[1] = 1'b1;
        tick(); clr();
        chk("R10 quiesce entry", 32'(stt(1)), 32'd7);

        // R11 and R13 with only thread 1 active
        act = 4'b0010;
        #1;
        chk("R11 nothing to fetch", 32'(sact), 32'd0);
        bd[0] = 1'b1; csq[0] = 1'b1; ctg[0 +: PW] = 32'h500;
        tick(); clr();
        chk("R13 inactive state", 32'(stt(0)), 32'd0);
        chk("R13 inactive pc", pct(0), 32'hFFFFFFFC);
        chk("R12 inactive no change", 32'(chg), 32'd0);
        act = '1;
        tick();
        chk("R13 no stored stall", 32'(stt(0)), 32'd0);
        chk("R11 active again", 32'(sact), 32'd1);
        csq[1] = 1'b1; ctg[1*PW +: PW] = 32'h0;
        tick(); clr();
        chk("R3 quiesce exit", 32'(stt(1)), 32'd2);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule